// File: doc/BRIEF.md
# DRAM Column Address Pin Mapper

This block takes a physical byte address and lays its column portion onto the thirteen DRAM address pins used during a read or write column command. The column field starts at address bit 3, because the data bus is eight bytes wide and the three byte-offset bits never leave the controller. The width of the field follows from the number of column address bits of the installed module. Seven bits give a 1K page and twelve bits give a 32K page. Pin 10 is reserved for the autoprecharge flag on every page size. When the field reaches eleven bits, the higher column bits skip pin 10 and continue on pins 11 and 12.

A small configuration register holds the page-size code. Software writes the module's column-bit count, and the block converts it to a code from 0 (1K) to 5 (32K). A count outside the range 7 to 12 gives code 7, which marks the slot as not installed. The pin word and a valid flag are registered on the rising clock edge. A synchronous active-high reset clears both and leaves the slot marked as not installed.

Top module: `colpin_map`

## Requirements
- R1: A synchronous reset clears the pin word to zero and drops the valid flag. After reset the slot stays disabled, with valid low, until a configuration write is made.
- R2: A configuration write of a column-bit count from 7 to 12 stores page code count-7 (0 = 1K up to 5 = 32K), and valid reads high from then on. Any other count stores code 7, and valid reads low.
- R3: Byte-offset address bits 2:0 never reach a pin. Pin 0 carries address bit 3.
- R4: With N column bits, where N is 7 to 10, pins N-1 down to 0 carry address bits N+2 down to 3.
- R5: With 11 column bits, pins 9 to 0 carry address bits 12 to 3, pin 11 carries address bit 13, and pin 12 is low.
- R6: With 12 column bits, pins 9 to 0 carry address bits 12 to 3, pin 11 carries bit 13, and pin 12 carries bit 14.
- R7: Whenever the slot is valid, pin 10 carries the autoprecharge request, whatever the page size.
- R8: Pins above the column field are driven low. Address bits above the field have no effect on any pin.
- R9: While the slot is disabled, the pin word is all zero whatever the address and autoprecharge inputs.
- R10: The pin word and valid flag reflect the inputs sampled at the previous rising edge. A configuration write changes the mapping from the edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Store the column-bit count on this edge |
| cfg_cols_i | input | 4 | Number of column address bits of the module |
| pa_i | input | 15 | Physical byte address; bits 14:3 hold the column field |
| ap_req_i | input | 1 | Autoprecharge request for this column command |
| ma_o | output | 13 | Registered DRAM address pin word |
| ma_vld_o | output | 1 | Slot installed and mapping valid |

## Verification
The address and autoprecharge inputs appear on the pins one rising edge after they are sampled. A configuration write needs two edges to show: one to store the code and one to register a pin word under that code. The bench drives every input on the falling edge and checks the outputs on the next falling edge, which falls after exactly one rising edge. Each reconfiguration finishes its write cycle before the address under test is applied. The latency scenario also checks the outputs before that edge, to confirm they still hold the old word.

// File: rtl/colmap_pkg.sv
package colmap_pkg;

  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] pg_code_t;

  // code for an uninstalled slot or an unsupported column count
  localparam pg_code_t CODE_OFF = 3'd7;

endpackage

// File: rtl/colmap_cfg.sv
module colmap_cfg
  import colmap_pkg::*;
#(
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cols_i,
  output pg_code_t         code_o
);

  pg_code_t code_d;
  pg_code_t code_q;

  // column-bit count -> page code; unsupported counts fall to CODE_OFF
  always_comb begin
    if (cols_i >= CNT_W'(MIN_COLS) && cols_i <= CNT_W'(MAX_COLS))
      code_d = CODE_W'(cols_i - CNT_W'(MIN_COLS));
    else
      code_d = CODE_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst)
      code_q <= CODE_OFF;
    else if (we_i)
      code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/colmap_lane.sv
module colmap_lane #(
  parameter int SRC   = 0,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] ncol_i,
  input  logic             bit_i,
  output logic             pin_o
);

  // the column bit at field position SRC exists only if the field is wider
  assign pin_o = (ncol_i > CNT_W'(SRC)) & bit_i;

endmodule

// File: rtl/colpin_map.sv
module colpin_map
  import colmap_pkg::*;
#(
  parameter int MA_W     = 13,
  parameter int AP_PIN   = 10,
  parameter int OFS      = 3,
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12,
  parameter int CNT_W    = 4,
  parameter int PA_W     = MAX_COLS + OFS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_cols_i,
  input  logic [PA_W-1:0]  pa_i,
  input  logic             ap_req_i,
  output logic [MA_W-1:0]  ma_o,
  output logic             ma_vld_o
);

  localparam int WA_W     = PA_W - OFS;
  localparam int CODE_MAX = MAX_COLS - MIN_COLS;

  pg_code_t          code_q;
  logic              code_ok;
  logic [CNT_W-1:0]  ncol;
  logic [WA_W-1:0]   wa;
  logic [MA_W-1:0]   map_w;
  logic [MA_W-1:0]   ma_q;
  logic              vld_q;

  colmap_cfg #(
    .MIN_COLS (MIN_COLS),
    .MAX_COLS (MAX_COLS),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we_i   (cfg_we_i),
    .cols_i (cfg_cols_i),
    .code_o (code_q)
  );

  assign code_ok = (code_q <= CODE_W'(CODE_MAX));
  assign ncol    = CNT_W'(code_q) + CNT_W'(MIN_COLS);

  // 8-byte bus: drop the byte offset, leaving the word address
  assign wa = WA_W'(pa_i >> OFS);

  for (genvar p = 0; p < MA_W; p++) begin : g_pin
    if (p == AP_PIN) begin : g_ap
      assign map_w[p] = ap_req_i;
    end else begin : g_col
      localparam int SRC = (p < AP_PIN) ? p : p - 1;
      if (SRC < WA_W) begin : g_live
        colmap_lane #(
          .SRC   (SRC),
          .CNT_W (CNT_W)
        ) u_lane (
          .ncol_i (ncol),
          .bit_i  (wa[SRC]),
          .pin_o  (map_w[p])
        );
      end else begin : g_tie
        assign map_w[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ma_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ma_q  <= code_ok ? map_w : '0;
      vld_q <= code_ok;
    end
  end

  assign ma_o     = ma_q;
  assign ma_vld_o = vld_q;

endmodule

// File: rtl/colpin_map_chk.sv
module colpin_map_chk
  import colmap_pkg::*;
#(
  parameter int MA_W     = 13,
  parameter int AP_PIN   = 10,
  parameter int OFS      = 3,
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12,
  parameter int PA_W     = 15
) (
  input logic            clk,
  input logic            rst,
  input logic [PA_W-1:0] pa_i,
  input logic            ap_req_i,
  input logic [MA_W-1:0] ma_o,
  input logic            ma_vld_o,
  input pg_code_t        code_q
);

  localparam int CODE_MAX = MAX_COLS - MIN_COLS;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ma_o == '0 && !ma_vld_o)); // R1

  AST_VLD_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (ma_vld_o == ($past(code_q) <= CODE_W'(CODE_MAX)))); // R2

  AST_PIN0_WORD_BIT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ma_vld_o) |-> (ma_o[0] == $past(pa_i[OFS]))); // R3

  AST_AP_ON_PIN: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ma_vld_o) |-> (ma_o[AP_PIN] == $past(ap_req_i))); // R7

  AST_TOP_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ma_vld_o && $past(code_q) < CODE_W'(CODE_MAX)) |-> !ma_o[MA_W-1]); // R8

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ma_vld_o |-> (ma_o == '0)); // R9

endmodule

bind colpin_map colpin_map_chk #(
  .MA_W     (MA_W),
  .AP_PIN   (AP_PIN),
  .OFS      (OFS),
  .MIN_COLS (MIN_COLS),
  .MAX_COLS (MAX_COLS),
  .PA_W     (PA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pa_i     (pa_i),
  .ap_req_i (ap_req_i),
  .ma_o     (ma_o),
  .ma_vld_o (ma_vld_o),
  .code_q   (code_q)
);

// File: tb/colpin_map_bench.sv
module colpin_map_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_cols = 4'd0;
  logic [14:0] pa = '0;
  logic        ap = 1'b0;
  logic [12:0] ma;
  logic        vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  colpin_map u_colpin_map (
    .clk        (clk),
    .rst        (rst),
    .cfg_we_i   (cfg_we),
    .cfg_cols_i (cfg_cols),
    .pa_i       (pa),
    .ap_req_i   (ap),
    .ma_o       (ma),
    .ma_vld_o   (vld)
  );

  // requirement model: fill pins upward from pin 0 with bits 3.., skipping pin 10
  function automatic logic [12:0] model(input logic [14:0] a, input logic r, input int cols);
    logic [12:0] m = '0;
    int k = 0;
    if (cols < 7 || cols > 12) return '0;
    for (int pin = 0; pin < 13; pin++) begin
      if (pin == 10) m[pin] = r;
      else if (k < cols) begin
        m[pin] = a[3 + k];
        k++;
      end
    end
    return m;
  endfunction

  task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic configure(input int cols);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_cols = 4'(cols);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic apply(input logic [14:0] a, input logic r);
    pa = a;
    ap = r;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ma in reset", ma, 13'h0);
    chk("R1 valid in reset", {12'h0, vld}, 13'h0);
    rst = 1'b0;
    apply(15'h7fff, 1'b1);
    chk("R1 valid before config", {12'h0, vld}, 13'h0);
    chk("R1 ma before config", ma, 13'h0);
  endtask

  task automatic t_code_range;
    for (int c = 0; c < 16; c++) begin
      configure(c);
      apply(15'h7fff, 1'b1);
      chk($sformatf("R2 valid cols=%0d", c), {12'h0, vld}, (c >= 7 && c <= 12) ? 13'h1 : 13'h0);
      if (c < 7 || c > 12) chk($sformatf("R9 zero cols=%0d", c), ma, 13'h0);
    end
  endtask

  task automatic t_small;
    logic [14:0] pats [4] = '{15'h7fff, 15'h5555, 15'h2aaa, 15'h1238};
    for (int c = 7; c <= 10; c++) begin
      configure(c);
      foreach (pats[i]) begin
        apply(pats[i], i[0]);
        chk($sformatf("R4 cols=%0d pat=%h", c, pats[i]), ma, model(pats[i], i[0], c));
      end
    end
    configure(7);
    apply(15'h7fff, 1'b0);
    chk("R8 1K high pins low", ma, 13'h007f);
    configure(12);
    apply(15'h0007, 1'b0);
    chk("R3 offset bits ignored", ma, 13'h0);
    apply(15'h0008, 1'b0);
    chk("R3 pin0 carries bit3", ma, 13'h0001);
  endtask

  task automatic t_16k;
    configure(11);
    apply(15'h2000, 1'b0);
    chk("R5 pin11 carries bit13", ma, 13'h0800);
    apply(15'h4000, 1'b0);
    chk("R5 pin12 low", ma, 13'h0);
    apply(15'h1ff8, 1'b0);
    chk("R5 low field", ma, 13'h03ff);
  endtask

  task automatic t_32k;
    configure(12);
    apply(15'h4000, 1'b0);
    chk("R6 pin12 carries bit14", ma, 13'h1000);
    apply(15'h7fff, 1'b0);
    chk("R6 full field", ma, 13'h1bff);
    apply(15'h6aa8, 1'b1);
    chk("R6 mixed", ma, model(15'h6aa8, 1'b1, 12));
  endtask

  task automatic t_ap;
    for (int c = 7; c <= 12; c++) begin
      configure(c);
      apply(15'h0000, 1'b1);
      chk($sformatf("R7 ap cols=%0d", c), ma, 13'h0400);
      apply(15'h0000, 1'b0);
      chk($sformatf("R7 ap low cols=%0d", c), ma, 13'h0);
    end
  endtask

  task automatic t_latency;
    configure(12);
    apply(15'h1238, 1'b0);
    chk("R10 first word", ma, model(15'h1238, 1'b0, 12));
    pa = 15'h7ff8;
    ap = 1'b1;
    #5;
    chk("R10 held before edge", ma, model(15'h1238, 1'b0, 12));
    @(negedge clk);
    chk("R10 new word after edge", ma, model(15'h7ff8, 1'b1, 12));
    cfg_we   = 1'b1;
    cfg_cols = 4'd7;
    @(negedge clk);
    cfg_we   = 1'b0;
    chk("R10 old code on write edge", ma, model(15'h7ff8, 1'b1, 12));
    @(negedge clk);
    chk("R10 new code next edge", ma, model(15'h7ff8, 1'b1, 7));
  endtask

  task automatic t_midreset;
    configure(10);
    apply(15'h7fff, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 ma cleared", ma, 13'h0);
    chk("R1 valid cleared", {12'h0, vld}, 13'h0);
    rst = 1'b0;
    apply(15'h7fff, 1'b1);
    chk("R1 disabled after reset", {12'h0, vld}, 13'h0);
  endtask

  initial begin
    t_reset();
    t_code_range();
    t_small();
    t_16k();
    t_32k();
    t_ap();
    t_latency();
    t_midreset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule